// File: doc/BRIEF.md
# Status Register and Write Guard

This block keeps the eight-bit configuration and status byte of a serial memory with an attached supervisor, and decides for every write request whether it may proceed. A serial command decoder in front of it sends single-cycle strobes: enable writes, disable writes (which also clears the software flag), set the flag, write the status byte (with its data byte), and write the array (with its byte address). The block answers each write request one cycle later with exactly one of two pulses, allowed or refused, and it times the nonvolatile busy period of every accepted write itself.

Two mechanisms refuse writes. The block-lock code protects the top quarter, the top half, or all of the array. A lock bit in the byte, combined with the write-protect pin held low, freezes the status byte while array writes still pass. The latch that enables writes is cleared whenever a write cycle ends, so every write needs a fresh enable. The nonvolatile fields are ordinary registers that reset to their factory values.

Top module: `statreg_guard`

## Requirements
- R1: After reset the status byte reads 0x30: bit 7 lock bit 0, bit 6 flag 0, bits 5:4 watchdog select 11, bits 3:2 block-lock code 00, bit 1 write latch 0, bit 0 busy 0; the watchdog select output reads 11.
- R2: An enable strobe sets bit 1 in the next cycle; a disable strobe clears both bit 1 and bit 6 in the next cycle.
- R3: A flag-set strobe sets bit 6 in the next cycle without changing the other bits.
- R4: While bit 1 is 0, every array or status write request is refused and changes no bit of the status byte.
- R5: The block-lock code protects by the two top address bits: 00 nothing, 01 addresses whose top two bits are 11, 10 addresses whose top bit is 1, 11 every address. A write to a protected address is refused; a write elsewhere with bit 1 set and no busy period is allowed.
- R6: With bit 7 at 1 and the write-protect pin low, status writes are refused while array writes to unprotected addresses are still allowed; with the pin high, status writes are allowed.
- R7: The allowed or refused pulse appears in the cycle after the request. An allowed write sets bit 0 for exactly BUSY_CYCLES cycles; when bit 0 falls, bit 1 is 0.
- R8: An allowed status write loads data bits 7 to 2 into bits 7 to 2 when its busy period ends, never earlier; data bits 1 and 0 are ignored; the watchdog select output follows bits 5:4.
- R9: Any write request made while bit 0 is 1 is refused.
- R10: An allowed status write completes even if the pin goes low during its busy period with bit 7 set, and every later status write is then refused.
- R11: Each write request yields exactly one outcome pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-up reset |
| opWren | input | 1 | Enable-writes strobe |
| opWrdi | input | 1 | Disable-writes and clear-flag strobe |
| opSflb | input | 1 | Set-flag strobe |
| opWrsr | input | 1 | Status write request |
| wrsrData | input | 8 | Data byte of the status write |
| opArrayWr | input | 1 | Array write request |
| arrayAddr | input | ADDR_W | Byte address of the array write |
| wpPin | input | 1 | Write-protect pin, low to protect |
| statusByte | output | 8 | Status byte for reads |
| wdSel | output | 2 | Watchdog period select |
| arrayWrOk | output | 1 | Array write allowed pulse |
| arrayWrDeny | output | 1 | Array write refused pulse |
| statusWrOk | output | 1 | Status write allowed pulse |
| statusWrDeny | output | 1 | Status write refused pulse |

## Verification
A wrong write latch or lock field shows up one cycle after the next write request as the wrong outcome pulse, and a wrong busy counter shows as bit 0 falling early or late, which the bench samples on the last busy cycle and the first idle cycle. Staged status data applied too early shows as bits 7 to 2 changing during the busy period, so the bench reads the byte while busy and again right after. Random sequences of strobes, addresses, data and pin levels are compared each cycle of interest against a model of the byte.

// File: rtl/statreg_pkg.sv
package statreg_pkg;
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic setFlag;
    logic clrFlag;
    logic capCfg;
    logic commit;
  } ctlStrobes_t;
endpackage

// File: rtl/statreg_ctrl.sv
module statreg_ctrl
  import statreg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opWren,
  input  logic              opWrdi,
  input  logic              opSflb,
  input  logic              opWrsr,
  input  logic              opArrayWr,
  input  logic [ADDR_W-1:0] arrayAddr,
  input  logic              wpPin,
  input  logic              wel,
  input  logic              wpen,
  input  logic [1:0]        blCode,
  output ctlStrobes_t       strb,
  output logic              busy,
  output logic              arrayWrOk,
  output logic              arrayWrDeny,
  output logic              statusWrOk,
  output logic              statusWrDeny
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] busyCnt;
  logic             protHit;
  logic             arrAccept;
  logic             statAccept;
  logic [1:0]       topBits;

  assign topBits = arrayAddr[ADDR_W-1 -: 2];
  assign busy    = (busyCnt != '0);

  always_comb begin
    unique case (blCode)
      2'b01:   protHit = (topBits == 2'b11);
      2'b10:   protHit = topBits[1];
      2'b11:   protHit = 1'b1;
      default: protHit = 1'b0;
    endcase
  end

  assign arrAccept  = opArrayWr & wel & ~busy & ~protHit;
  assign statAccept = opWrsr & wel & ~busy & ~(wpen & ~wpPin);

  always_comb begin
    strb.setWel  = opWren;
    strb.clrWel  = opWrdi;
    strb.setFlag = opSflb;
    strb.clrFlag = opWrdi;
    strb.capCfg  = statAccept;
    strb.commit  = (busyCnt == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt      <= '0;
      arrayWrOk    <= 1'b0;
      arrayWrDeny  <= 1'b0;
      statusWrOk   <= 1'b0;
      statusWrDeny <= 1'b0;
    end else begin
      arrayWrOk    <= arrAccept;
      arrayWrDeny  <= opArrayWr & ~arrAccept;
      statusWrOk   <= statAccept;
      statusWrDeny <= opWrsr & ~statAccept;
      if (arrAccept || statAccept) busyCnt <= CNT_LOAD;
      else if (busy)               busyCnt <= busyCnt - CNT_W'(1);
    end
  end

  assert_no_latch_refuse_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opArrayWr && !wel) |=> (arrayWrDeny && !arrayWrOk));

  assert_full_lock_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opArrayWr && blCode == 2'b11) |=> !arrayWrOk);

  assert_rom_lock_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opWrsr && wpen && !wpPin) |=> (statusWrDeny && !statusWrOk));

  assert_busy_refuse_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (opArrayWr || opWrsr)) |=> !(arrayWrOk || statusWrOk));
endmodule

// File: rtl/statreg_data.sv
module statreg_data
  import statreg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strb,
  input  logic [7:0]  wrsrData,
  input  logic        busy,
  output logic        wel,
  output logic        wpen,
  output logic [1:0]  blCode,
  output logic [1:0]  wdCode,
  output logic [7:0]  statusByte
);
  logic       flag;
  logic [5:0] pendCfg;
  logic       pendValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wpen      <= 1'b0;
      flag      <= 1'b0;
      wdCode    <= 2'b11;
      blCode    <= 2'b00;
      wel       <= 1'b0;
      pendCfg   <= '0;
      pendValid <= 1'b0;
    end else begin
      if (strb.setWel)  wel  <= 1'b1;
      if (strb.clrWel)  wel  <= 1'b0;
      if (strb.setFlag) flag <= 1'b1;
      if (strb.clrFlag) flag <= 1'b0;
      if (strb.capCfg) begin
        pendCfg   <= wrsrData[7:2];
        pendValid <= 1'b1;
      end
      if (strb.commit) begin
        wel <= 1'b0;
        if (pendValid) begin
          wpen      <= pendCfg[5];
          flag      <= pendCfg[4];
          wdCode    <= pendCfg[3:2];
          blCode    <= pendCfg[1:0];
          pendValid <= 1'b0;
        end
      end
    end
  end

  assign statusByte = {wpen, flag, wdCode, blCode, wel, busy};

  assert_cfg_held_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.commit) |=> $stable({wpen, wdCode, blCode}));
endmodule

// File: rtl/statreg_guard.sv
module statreg_guard
  import statreg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opWren,
  input  logic              opWrdi,
  input  logic              opSflb,
  input  logic              opWrsr,
  input  logic [7:0]        wrsrData,
  input  logic              opArrayWr,
  input  logic [ADDR_W-1:0] arrayAddr,
  input  logic              wpPin,
  output logic [7:0]        statusByte,
  output logic [1:0]        wdSel,
  output logic              arrayWrOk,
  output logic              arrayWrDeny,
  output logic              statusWrOk,
  output logic              statusWrDeny
);
  ctlStrobes_t strb;
  logic        busy;
  logic        wel;
  logic        wpen;
  logic [1:0]  blCode;

  statreg_ctrl #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .opWren(opWren), .opWrdi(opWrdi), .opSflb(opSflb),
    .opWrsr(opWrsr), .opArrayWr(opArrayWr), .arrayAddr(arrayAddr), .wpPin(wpPin),
    .wel(wel), .wpen(wpen), .blCode(blCode), .strb(strb), .busy(busy),
    .arrayWrOk(arrayWrOk), .arrayWrDeny(arrayWrDeny),
    .statusWrOk(statusWrOk), .statusWrDeny(statusWrDeny)
  );

  statreg_data data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrsrData(wrsrData), .busy(busy),
    .wel(wel), .wpen(wpen), .blCode(blCode), .wdCode(wdSel), .statusByte(statusByte)
  );

  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({arrayWrOk, arrayWrDeny, statusWrOk, statusWrDeny}));

  assert_grant_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (arrayWrOk || statusWrOk) |-> statusByte[0]);

  assert_latch_clear_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusByte[0]) |-> !statusByte[1]);
endmodule

// File: tb/statreg_guard_tb_top.sv
module statreg_guard_tb_top;
  localparam int AW = 12;
  localparam int BC = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opWren = 0, opWrdi = 0, opSflb = 0, opWrsr = 0, opArrayWr = 0;
  logic [7:0] wrsrData = '0;
  logic [AW-1:0] arrayAddr = '0;
  logic wpPin = 1'b1;
  logic [7:0] statusByte;
  logic [1:0] wdSel;
  logic arrayWrOk, arrayWrDeny, statusWrOk, statusWrDeny;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic eWpen = 0, eFlag = 0, eWel = 0;
  logic [1:0] eWd = 2'b11, eBl = 2'b00;

  always #5 clk = ~clk;

  statreg_guard #(.ADDR_W(AW), .BUSY_CYCLES(BC)) dut_i (
    .clk(clk), .rstN(rstN), .opWren(opWren), .opWrdi(opWrdi), .opSflb(opSflb),
    .opWrsr(opWrsr), .wrsrData(wrsrData), .opArrayWr(opArrayWr), .arrayAddr(arrayAddr),
    .wpPin(wpPin), .statusByte(statusByte), .wdSel(wdSel), .arrayWrOk(arrayWrOk),
    .arrayWrDeny(arrayWrDeny), .statusWrOk(statusWrOk), .statusWrDeny(statusWrDeny)
  );

  function automatic logic isProt(input logic [1:0] bl, input logic [AW-1:0] a);
    case (bl)
      2'b01:   return a[AW-1:AW-2] == 2'b11;
      2'b10:   return a[AW-1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] expByte(input logic wip);
    return {eWpen, eFlag, eWd, eBl, eWel, wip};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  task automatic simpleOp(input int kind);
    @(negedge clk);
    case (kind)
      0: opWren = 1;
      1: opWrdi = 1;
      default: opSflb = 1;
    endcase
    @(negedge clk);
    opWren = 0; opWrdi = 0; opSflb = 0;
    case (kind)
      0: eWel = 1;
      1: begin eWel = 0; eFlag = 0; end
      default: eFlag = 1;
    endcase
    check(kind == 0 ? "R2 enable" : (kind == 1 ? "R2 disable" : "R3 flag"),
          statusByte, expByte(1'b0));
  endtask

  // waits out a busy period that started at the last edge; checks R7 timing
  task automatic waitBusy(input logic [7:0] busyView);
    check("R7 busy on", statusByte[0], 1'b1);
    repeat (BC - 1) @(negedge clk);
    check("R7 busy last cycle", statusByte[0], 1'b1);
    check("R8 no early load", statusByte, busyView);
    @(negedge clk);
    check("R7 busy off", statusByte[0], 1'b0);
  endtask

  task automatic arrWrite(input logic [AW-1:0] a);
    logic ok;
    ok = eWel && !isProt(eBl, a);
    @(negedge clk);
    opArrayWr = 1; arrayAddr = a;
    @(negedge clk);
    opArrayWr = 0;
    check("R5 array outcome", {arrayWrOk, arrayWrDeny, statusWrOk, statusWrDeny},
          {ok, !ok, 2'b00});
    if (ok) begin
      waitBusy(expByte(1'b1));
      eWel = 0;
    end
    check("R4 array byte", statusByte, expByte(1'b0));
  endtask

  task automatic statWrite(input logic [7:0] d, input logic dropPin);
    logic ok;
    ok = eWel && !(eWpen && !wpPin);
    @(negedge clk);
    opWrsr = 1; wrsrData = d;
    @(negedge clk);
    opWrsr = 0;
    check("R6 status outcome", {arrayWrOk, arrayWrDeny, statusWrOk, statusWrDeny},
          {2'b00, ok, !ok});
    if (ok) begin
      if (dropPin) wpPin = 0;
      waitBusy(expByte(1'b1));
      eWel = 0; eWpen = d[7]; eFlag = d[6]; eWd = d[5:4]; eBl = d[3:2];
      check("R8 watchdog out", wdSel, eWd);
    end
    check("R8 status byte", statusByte, expByte(1'b0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 reset byte", statusByte, 8'h30);
    check("R1 watchdog", wdSel, 2'b11);

    // R4: no latch, both writes refused
    arrWrite(12'h005);
    statWrite(8'hFF, 1'b0);
    // R2, R3
    simpleOp(2);
    simpleOp(0);
    simpleOp(1);
    // R7/R8: status write with low bits ignored, block code 01
    simpleOp(0);
    statWrite(8'b0010_0111, 1'b0);
    check("R8 low bits ignored", statusByte[1:0], 2'b00);
    // R5: code 01
    simpleOp(0); arrWrite(12'hC00);
    simpleOp(0); arrWrite(12'hBFF);
    // R9: request during busy
    simpleOp(0);
    @(negedge clk); opArrayWr = 1; arrayAddr = 12'h010;
    @(negedge clk); opArrayWr = 0;
    check("R7 array ok", arrayWrOk, 1'b1);
    @(negedge clk); opWrsr = 1; wrsrData = 8'h00;
    @(negedge clk); opWrsr = 0;
    check("R9 status refused while busy", statusWrDeny, 1'b1);
    repeat (BC) @(negedge clk);
    eWel = 0;
    check("R9 byte after", statusByte, expByte(1'b0));
    // R5: code 10 and 11
    simpleOp(0); statWrite(8'b0000_1000, 1'b0);
    simpleOp(0); arrWrite(12'h800);
    simpleOp(0); arrWrite(12'h7FF);
    simpleOp(0); statWrite(8'b0000_1100, 1'b0);
    simpleOp(0); arrWrite(12'h000);
    // R6: lock bit with pin high then low
    simpleOp(0); statWrite(8'b1000_0000, 1'b0);
    wpPin = 0;
    simpleOp(0); statWrite(8'h00, 1'b0);
    arrWrite(12'hFFF);
    wpPin = 1;
    // R10: accepted status write survives the pin dropping
    simpleOp(0); statWrite(8'b1001_0100, 1'b1);
    check("R10 lock kept", statusByte[7], 1'b1);
    simpleOp(0); statWrite(8'h00, 1'b0);
    wpPin = 1;
    simpleOp(0); statWrite(8'h30, 1'b0);

    // random phase (R11 outcomes, model compare)
    begin
      int unsigned s;
      s = $urandom(32'h5A17);
      for (int i = 0; i < 300; i++) begin
        int k;
        k = $urandom_range(0, 5);
        wpPin = ($urandom_range(0, 3) != 0);
        case (k)
          0, 1: simpleOp(0);
          2: simpleOp($urandom_range(1, 2));
          3, 4: arrWrite(AW'($urandom));
          default: statWrite(8'($urandom) & 8'h6F | (($urandom_range(0, 7) == 0) ? 8'h80 : 8'h00),
                             1'b0);
        endcase
      end
    end
    finishRun();
  end
endmodule